// File: doc/BRIEF.md
# Expanded-Memory Page Mapper

This block holds thirty-two page entries that remap 16 KB windows of the low CPU address space onto physical pages of a 16 MB space. Software programs the entries through a group of three byte-wide I/O ports. The group sits at one of two base addresses, and a bit of the EMS control byte picks which one. The third port of the group is a pointer. It selects the entry that the first two ports reach. When its increment bit is set, it steps to the next entry after each write to the high register.

On the memory side the block is purely combinational. It compares the CPU address with the window of every enabled entry. On a match it replaces the page bits with the entry's 10-bit physical page number and raises a hit flag. An address that matches no window leaves the block unchanged.

The windows of entries 0 to 23 follow one another from 0x40000. The windows of entries 24 to 31 start 192 KB higher, at 0xD0000. The gap between them stays untranslated.

Top module: `ems_page_mapper`

## Requirements
- R1: After reset every low register reads 0xFF, every high register reads 0x03 (bit 7 clear, so no page is enabled), and the pointer reads 0x00.
- R2: The port group at base 0x208 is active when control bit 6 is 1 and control bit 0 is 0. The group at base 0x218 is active when both bits are 1. A group that is not active ignores writes, and a read from it returns 0xFF.
- R3: In the active group, base+0 accesses the low register of the entry selected by pointer bits 4:0, base+1 accesses that entry's high register, and base+2 accesses the full 8-bit pointer.
- R4: A write to the high register while pointer bit 7 is 1 advances pointer bits 4:0 by one modulo 32. Pointer bits 7:5 keep their value.
- R5: The pointer does not move after a high-register write while pointer bit 7 is 0, nor after any low-register write.
- R6: Entry n below 24 covers the 16 KB window at (n+16)×0x4000. Entry n of 24 or above covers the window at (n+16)×0x4000+0x30000.
- R7: When control bit 7 is 1 and the entry's high bit 7 is 1, an address inside the entry's window is output as {high[1:0], low[7:0], addr[13:0]}, and map_hit is 1.
- R8: An address outside every enabled window, or any address while control bit 7 is 0, is output unchanged with map_hit 0.
- R9: A register write changes the translation from the clock edge that captures it. Before that edge the old mapping still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle per byte |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data; 0xFF when no mapper port is addressed |
| ems_ctrl | input | 8 | EMS control byte: bit 7 translate enable, bit 6 port enable, bit 0 group select |
| cpu_addr | input | 24 | CPU memory address |
| phys_addr | output | 24 | Translated or passed-through address |
| map_hit | output | 1 | Address fell inside an enabled window |

## Verification
The bench builds the block with its default parameters: 32 entries, 14 offset bits, a 10-bit page number, a 24-bit address, and the hole of 12 pages starting at entry 24. These values bring both edges of the hole within reach: the last window below it (entry 23), the first above it (entry 24), and the hole itself. They also bring the 5-bit wrap of the pointer from entry 31 to 0, and the extreme page numbers 0x000 and 0x3FF that fill the full address width.

// File: rtl/ems_pkg.sv
package ems_pkg;
  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_LOW  = 2'd1,
    PORT_HIGH = 2'd2,
    PORT_PTR  = 2'd3
  } ems_port_e;

  localparam int CTRL_XLATE_BIT = 7;
  localparam int CTRL_PORT_BIT  = 6;
  localparam int CTRL_ALT_BIT   = 0;
  localparam int HI_EN_BIT      = 7;
  localparam int PTR_INC_BIT    = 7;
  localparam logic [7:0] LOW_RESET  = 8'hFF;
  localparam logic [7:0] HIGH_RESET = 8'h03;
endpackage

// File: rtl/ems_io_decode.sv
module ems_io_decode
  import ems_pkg::*;
#(
  parameter int IO_W = 16,
  parameter logic [IO_W-1:0] BASE_A = 16'h0208,
  parameter logic [IO_W-1:0] BASE_B = 16'h0218
) (
  input  logic [IO_W-1:0] io_addr,
  input  logic            port_on,
  input  logic            use_alt,
  output ems_port_e       port_sel
);
  logic [IO_W-1:0] base;

  always_comb begin
    base     = use_alt ? BASE_B : BASE_A;
    port_sel = PORT_NONE;
    if (port_on) begin
      if (io_addr == base)                      port_sel = PORT_LOW;
      else if (io_addr == base + IO_W'(1))      port_sel = PORT_HIGH;
      else if (io_addr == base + IO_W'(2))      port_sel = PORT_PTR;
    end
  end
endmodule

// File: rtl/ems_page_regs.sv
module ems_page_regs
  import ems_pkg::*;
#(
  parameter int N_PAGES = 32,
  parameter int PPN_W   = 10,
  localparam int IDX_W  = $clog2(N_PAGES),
  localparam int HI_W   = PPN_W - 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  ems_port_e                     port_sel,
  input  logic [7:0]                    wdata,
  output logic [7:0]                    ptr,
  output logic [7:0]                    sel_lo,
  output logic [7:0]                    sel_hi,
  output logic [N_PAGES-1:0]            page_en,
  output logic [N_PAGES-1:0][PPN_W-1:0] page_ppn
);
  logic [N_PAGES-1:0][7:0] lo_q, lo_d, hi_q, hi_d;
  logic [7:0]              ptr_q, ptr_d;
  logic [IDX_W-1:0]        idx;
  logic                    wr_lo, wr_hi, wr_ptr;

  assign idx    = ptr_q[IDX_W-1:0];
  assign wr_lo  = io_wr && (port_sel == PORT_LOW);
  assign wr_hi  = io_wr && (port_sel == PORT_HIGH);
  assign wr_ptr = io_wr && (port_sel == PORT_PTR);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_lo) lo_d[idx] = wdata;
    if (wr_hi) hi_d[idx] = wdata;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (wr_ptr)
      ptr_d = wdata;
    else if (wr_hi && ptr_q[PTR_INC_BIT])
      ptr_d = {ptr_q[7:IDX_W], idx + IDX_W'(1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= {N_PAGES{LOW_RESET}};
      hi_q  <= {N_PAGES{HIGH_RESET}};
      ptr_q <= '0;
    end else begin
      if (wr_lo) lo_q <= lo_d;
      if (wr_hi) hi_q <= hi_d;
      if (wr_ptr || wr_hi) ptr_q <= ptr_d;
    end
  end

  assign ptr    = ptr_q;
  assign sel_lo = lo_q[idx];
  assign sel_hi = hi_q[idx];

  for (genvar i = 0; i < N_PAGES; i++) begin : g_out
    assign page_en[i]  = hi_q[i][HI_EN_BIT];
    assign page_ppn[i] = {hi_q[i][HI_W-1:0], lo_q[i]};
  end

  // R4: high write with the increment bit steps the index, keeps upper bits
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && ptr_q[PTR_INC_BIT]) |=>
      (ptr_q[IDX_W-1:0] == $past(ptr_q[IDX_W-1:0]) + IDX_W'(1)) &&
      (ptr_q[7:IDX_W] == $past(ptr_q[7:IDX_W])));

  // R5: no step without the increment bit, and never on a low write
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !wr_ptr && !(wr_hi && ptr_q[PTR_INC_BIT])) |=> $stable(ptr_q));

  // R2: without a write strobe nothing in the file changes
  assert_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(ptr_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/ems_xlate.sv
module ems_xlate #(
  parameter int N_PAGES   = 32,
  parameter int ADDR_W    = 24,
  parameter int OFS_W     = 14,
  parameter int PPN_W     = 10,
  parameter int WIN_FIRST = 16,
  parameter int HOLE_IDX  = 24,
  parameter int HOLE_SKIP = 12,
  localparam int PG_W     = ADDR_W - OFS_W,
  localparam int PA_W     = PPN_W + OFS_W
) (
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic                          xlate_on,
  input  logic [N_PAGES-1:0]            page_en,
  input  logic [N_PAGES-1:0][PPN_W-1:0] page_ppn,
  output logic [ADDR_W-1:0]             phys_addr,
  output logic                          map_hit,
  output logic [N_PAGES-1:0]            match
);
  for (genvar i = 0; i < N_PAGES; i++) begin : g_win
    localparam int WIN = i + WIN_FIRST + ((i >= HOLE_IDX) ? HOLE_SKIP : 0);
    localparam logic [PG_W-1:0] WIN_PG = PG_W'(WIN);
    assign match[i] = xlate_on && page_en[i] &&
                      (cpu_addr[ADDR_W-1:OFS_W] == WIN_PG);
  end

  always_comb begin
    phys_addr = cpu_addr;
    map_hit   = 1'b0;
    for (int i = 0; i < N_PAGES; i++) begin
      if (match[i]) begin
        phys_addr             = '0;
        phys_addr[PA_W-1:0]   = {page_ppn[i], cpu_addr[OFS_W-1:0]};
        map_hit               = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ems_page_mapper.sv
module ems_page_mapper
  import ems_pkg::*;
#(
  parameter int N_PAGES   = 32,
  parameter int ADDR_W    = 24,
  parameter int OFS_W     = 14,
  parameter int PPN_W     = 10,
  parameter int IO_W      = 16,
  parameter int WIN_FIRST = 16,
  parameter int HOLE_IDX  = 24,
  parameter int HOLE_SKIP = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_W-1:0]   io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [7:0]        ems_ctrl,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              map_hit
);
  ems_port_e                     port_sel;
  logic [7:0]                    ptr, sel_lo, sel_hi;
  logic [N_PAGES-1:0]            page_en;
  logic [N_PAGES-1:0][PPN_W-1:0] page_ppn;
  logic [N_PAGES-1:0]            match;
  logic                          unused_ctrl;

  assign unused_ctrl = ^ems_ctrl[5:1];

  ems_io_decode #(.IO_W(IO_W)) u_dec (
    .io_addr  (io_addr),
    .port_on  (ems_ctrl[CTRL_PORT_BIT]),
    .use_alt  (ems_ctrl[CTRL_ALT_BIT]),
    .port_sel (port_sel)
  );

  ems_page_regs #(.N_PAGES(N_PAGES), .PPN_W(PPN_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_wr    (io_wr),
    .port_sel (port_sel),
    .wdata    (io_wdata),
    .ptr      (ptr),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .page_en  (page_en),
    .page_ppn (page_ppn)
  );

  ems_xlate #(
    .N_PAGES(N_PAGES), .ADDR_W(ADDR_W), .OFS_W(OFS_W), .PPN_W(PPN_W),
    .WIN_FIRST(WIN_FIRST), .HOLE_IDX(HOLE_IDX), .HOLE_SKIP(HOLE_SKIP)
  ) u_xlate (
    .cpu_addr  (cpu_addr),
    .xlate_on  (ems_ctrl[CTRL_XLATE_BIT]),
    .page_en   (page_en),
    .page_ppn  (page_ppn),
    .phys_addr (phys_addr),
    .map_hit   (map_hit),
    .match     (match)
  );

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd) begin
      case (port_sel)
        PORT_LOW:  io_rdata = sel_lo;
        PORT_HIGH: io_rdata = sel_hi;
        PORT_PTR:  io_rdata = ptr;
        default:   io_rdata = 8'hFF;
      endcase
    end
  end

  // R2: with the port group switched off every read returns 0xFF
  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !ems_ctrl[CTRL_PORT_BIT]) |-> (io_rdata == 8'hFF));

  // R6: windows never overlap
  assert_one_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R7: a hit keeps the offset inside the page
  assert_keep_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    map_hit |-> (phys_addr[OFS_W-1:0] == cpu_addr[OFS_W-1:0]));

  // R8: a miss passes the address through
  assert_pass_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !map_hit |-> (phys_addr == cpu_addr));

  // R8: translation off means no hit
  assert_xlate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ems_ctrl[CTRL_XLATE_BIT] |-> !map_hit);
endmodule

// File: tb/ems_page_mapper_test.sv
module ems_page_mapper_test;
  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata, ems_ctrl;
  logic [23:0] cpu_addr, phys_addr;
  logic        map_hit;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ems_page_mapper uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ems_ctrl(ems_ctrl),
    .cpu_addr(cpu_addr), .phys_addr(phys_addr), .map_hit(map_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {cpu_addr, expected phys_addr, expected hit}
  localparam int NVEC = 11;
  localparam logic [48:0] VEC [NVEC] = '{
    {24'h040123, 24'h448123, 1'b1},  // entry 0, page 0x112
    {24'h043FFF, 24'h44BFFF, 1'b1},  // entry 0 last byte
    {24'h09FFFF, 24'h017FFF, 1'b1},  // entry 23, below the hole
    {24'h0D0000, 24'hAA8000, 1'b1},  // entry 24, above the hole
    {24'h0EFFFF, 24'hFFFFFF, 1'b1},  // entry 31, page 0x3FF
    {24'h03FFFF, 24'h03FFFF, 1'b0},  // just below window 0
    {24'h044000, 24'h044000, 1'b0},  // entry 1 disabled
    {24'h0A0000, 24'h0A0000, 1'b0},  // inside the hole
    {24'h0CFFFF, 24'h0CFFFF, 1'b0},  // last hole byte
    {24'h0F0000, 24'h0F0000, 1'b0},  // above entry 31
    {24'h140123, 24'h140123, 1'b0}   // upper address bits differ
  };

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic probe(input logic [23:0] a, output logic [23:0] pa, output logic hit);
    @(negedge clk);
    cpu_addr = a;
    #1 pa = phys_addr; hit = map_hit;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [23:0] pa;
    logic        hit;
    rst_n = 1'b0; io_addr = '0; io_wr = 0; io_rd = 0; io_wdata = '0;
    ems_ctrl = 8'h00; cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents through group A
    ems_ctrl = 8'h40;
    io_read(16'h0208, rd); check("R1 low reset", 24'(rd), 24'h0000FF);
    io_read(16'h0209, rd); check("R1 high reset", 24'(rd), 24'h000003);
    io_read(16'h020A, rd); check("R1 pointer reset", 24'(rd), 24'h000000);
    io_read(16'h021F, rd); check("R2 unrelated port", 24'(rd), 24'h0000FF);

    // R2 group B inactive: write ignored, read 0xFF
    io_read(16'h0218, rd); check("R2 inactive group B read", 24'(rd), 24'h0000FF);
    io_write(16'h0218, 8'h55);
    io_write(16'h021A, 8'h07);
    ems_ctrl = 8'h41;
    io_read(16'h0218, rd); check("R2 group B write ignored", 24'(rd), 24'h0000FF);
    io_read(16'h021A, rd); check("R2 pointer unchanged", 24'(rd), 24'h000000);
    io_read(16'h0208, rd); check("R2 inactive group A read", 24'(rd), 24'h0000FF);
    ems_ctrl = 8'h01;
    io_read(16'h0218, rd); check("R2 ports off", 24'(rd), 24'h0000FF);

    // R3/R4 program entries through group A with auto increment
    ems_ctrl = 8'h40;
    io_write(16'h020A, 8'h80);
    io_write(16'h0208, 8'h12);
    io_read(16'h020A, rd); check("R5 low write no step", 24'(rd), 24'h000080);
    io_write(16'h0209, 8'h81);
    io_read(16'h020A, rd); check("R4 step after high", 24'(rd), 24'h000081);
    io_write(16'h020A, 8'h97);
    io_write(16'h0208, 8'h05); io_write(16'h0209, 8'h80);
    io_write(16'h0208, 8'hAA); io_write(16'h0209, 8'h82);
    io_read(16'h020A, rd); check("R4 step into entry 25", 24'(rd), 24'h000099);
    io_write(16'h020A, 8'hBF);
    io_write(16'h0208, 8'hFF); io_write(16'h0209, 8'h83);
    io_read(16'h020A, rd); check("R4 wrap keeps upper bits", 24'(rd), 24'h0000A0);

    // R3 readback of entry 24
    io_write(16'h020A, 8'h18);
    io_read(16'h0208, rd); check("R3 low readback", 24'(rd), 24'h0000AA);
    io_read(16'h0209, rd); check("R3 high readback", 24'(rd), 24'h000082);

    // R5 high write without increment bit
    io_write(16'h020A, 8'h03);
    io_write(16'h0209, 8'h00);
    io_read(16'h020A, rd); check("R5 no step", 24'(rd), 24'h000003);

    // R8 translation disabled
    probe(24'h040123, pa, hit);
    check("R8 xlate off addr", pa, 24'h040123);
    check("R8 xlate off hit", 24'(hit), 24'h0);

    // R6/R7/R8 vector walk
    ems_ctrl = 8'hC0;
    for (int i = 0; i < NVEC; i++) begin
      probe(VEC[i][48:25], pa, hit);
      check(VEC[i][0] ? "R6 R7 mapped addr" : "R8 miss addr", pa, VEC[i][24:1]);
      check(VEC[i][0] ? "R7 hit flag" : "R8 hit flag", 24'(hit), 24'(VEC[i][0]));
    end

    // R9 disable entry 0: old mapping until the capturing edge
    cpu_addr = 24'h040123;
    io_write(16'h020A, 8'h00);
    @(negedge clk);
    io_addr = 16'h0209; io_wdata = 8'h01; io_wr = 1'b1;
    #1 check("R9 before edge", 24'(map_hit), 24'h1);
    @(negedge clk);
    io_wr = 1'b0;
    #1 check("R9 after edge", 24'(map_hit), 24'h0);
    check("R9 after edge addr", phys_addr, 24'h040123);

    // R2/R3 group B programming entry 1
    ems_ctrl = 8'hC1;
    io_write(16'h021A, 8'h01);
    io_write(16'h0218, 8'h00);
    io_write(16'h0219, 8'h80);
    probe(24'h044010, pa, hit);
    check("R3 group B mapped addr", pa, 24'h000010);
    check("R3 group B hit", 24'(hit), 24'h1);
    io_read(16'h0209, rd); check("R2 group A off in B mode", 24'(rd), 24'h0000FF);

    finish_run();
  end
endmodule